// File: doc/BRIEF.md
# Four-Bit Universal Shift Register

This block is a small storage register that moves data between serial and parallel form. It has a chain of four D-type stages and one system clock. Each cycle, a mode line selects one of two single-cycle strobes. With mode low, a shift strobe moves the word one place toward the last stage and takes a new bit from the serial input into the first stage. With mode high, a load strobe writes the whole parallel input word into the stages at once.

For serial-to-parallel conversion, hold mode low and pulse the shift strobe once per incoming bit. After four pulses the word appears on the stage outputs. For parallel-to-serial conversion, raise mode and pulse the load strobe, then drop mode and pulse the shift strobe. The bits then leave one at a time from the serial output, which follows the last stage.

A strobe that does not match the current mode has no effect. A synchronous reset clears the stages and overrides everything else. The stage count is a parameter with a default of four.

Top module: `shreg_univ`

## Requirements
- R1: When `rst` is high at a rising clock edge, all stages read 0 after that edge, whatever the strobes and mode are.
- R2: When `mode`=0 and `shift_stb`=1 at an edge, `q[0]` takes `ser_in` and each `q[i]` takes the old `q[i-1]`. Stage 1 is `q[0]` and the last stage is `q[WIDTH-1]`.
- R3: When `mode`=1 and `load_stb`=1 at an edge, `q[i]` takes `par_in[i]` for every bit i.
- R4: A `shift_stb` pulse while `mode`=1 and `load_stb`=0 leaves `q` unchanged.
- R5: A `load_stb` pulse while `mode`=0 and `shift_stb`=0 leaves `q` unchanged.
- R6: When both strobes are high in one cycle, only the operation that matches `mode` takes effect: a shift for `mode`=0, a load for `mode`=1.
- R7: With no strobe asserted, `q` holds its value.
- R8: `ser_out` always equals the last stage `q[WIDTH-1]`.
- R9: After four shifts with `mode`=0, the first bit received is in `q[3]` and the last bit received is in `q[0]`.
- R10: After a load followed by shifts, `ser_out` presents `par_in[3]`, `par_in[2]`, `par_in[1]` and `par_in[0]` in that order. One bit is presented before the first shift and one after each of the next three shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high clear |
| mode | input | 1 | 0 selects shift, 1 selects parallel load |
| shift_stb | input | 1 | Single-cycle shift strobe |
| load_stb | input | 1 | Single-cycle load strobe |
| ser_in | input | 1 | Serial data into stage 1 |
| par_in | input | WIDTH | Parallel word for loading |
| q | output | WIDTH | Stage outputs, q[0] is stage 1 |
| ser_out | output | 1 | Serial output from the last stage |

## Verification
The hardest case to reach is a strobe that arrives in the wrong mode. The case is worst when both strobes fire together, because a faulty gate would still look correct during normal conversion traffic. The stimulus first sets up a known non-zero word. It then applies each mismatched strobe alone and both strobes together in each mode, and it does this with serial and parallel inputs chosen to differ from the stored word. It also asserts reset while strobes are active. A random phase mixes every mode and strobe combination, and the bench compares it with a behavioural model on every cycle.

// File: rtl/usr_pkg.sv
package usr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } usr_op_e;

endpackage

// File: rtl/usr_ctrl.sv
module usr_ctrl
  import usr_pkg::*;
(
  input  logic    rst,
  input  logic    mode,
  input  logic    shift_stb,
  input  logic    load_stb,
  output usr_op_e op
);

  // Reset wins; otherwise only the strobe matching mode is honoured.
  always_comb begin
    if (rst)
      op = OP_CLEAR;
    else if (mode)
      op = load_stb ? OP_LOAD : OP_HOLD;
    else
      op = shift_stb ? OP_SHIFT : OP_HOLD;
  end

endmodule

// File: rtl/usr_stage.sv
module usr_stage
  import usr_pkg::*;
(
  input  logic    clk,
  input  usr_op_e op,
  input  logic    prev_d,
  input  logic    par_d,
  output logic    q
);

  logic nxt;

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = 1'b0;
      OP_SHIFT: nxt = prev_d;
      OP_LOAD:  nxt = par_d;
      default:  nxt = q;
    endcase
  end

  always_ff @(posedge clk) q <= nxt;

endmodule

// File: rtl/shreg_univ.sv
module shreg_univ
  import usr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode,
  input  logic             shift_stb,
  input  logic             load_stb,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q,
  output logic             ser_out
);

  localparam int LAST = WIDTH - 1;

  usr_op_e op;

  usr_ctrl u_ctrl (
    .rst       (rst),
    .mode      (mode),
    .shift_stb (shift_stb),
    .load_stb  (load_stb),
    .op        (op)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic feed;
    if (i == 0) begin : g_head
      assign feed = ser_in;
    end else begin : g_link
      assign feed = q[i-1];
    end
    usr_stage u_stage (
      .clk    (clk),
      .op     (op),
      .prev_d (feed),
      .par_d  (par_in[i]),
      .q      (q[i])
    );
  end

  assign ser_out = q[LAST];

endmodule

// File: rtl/shreg_univ_chk.sv
module shreg_univ_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             mode,
  input logic             shift_stb,
  input logic             load_stb,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] q,
  input logic             ser_out
);

  // R1
  clear_chk: assert property (@(posedge clk) rst |=> (q == '0));

  // R2
  shift_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode && shift_stb) |=> (q == {$past(q[WIDTH-2:0]), $past(ser_in)}));

  // R3
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (mode && load_stb) |=> (q == $past(par_in)));

  // R4 R5 R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode && !load_stb) || (!mode && !shift_stb)) |=> $stable(q));

  // R8
  tail_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode && shift_stb) |=> (ser_out == $past(q[WIDTH-2])));

endmodule

bind shreg_univ shreg_univ_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode      (mode),
  .shift_stb (shift_stb),
  .load_stb  (load_stb),
  .ser_in    (ser_in),
  .par_in    (par_in),
  .q         (q),
  .ser_out   (ser_out)
);

// File: tb/sim_shreg_univ.sv
`timescale 1ns/1ps
module sim_shreg_univ;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode = 1'b0;
  logic         shift_stb = 1'b0;
  logic         load_stb = 1'b0;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic [W-1:0] q;
  logic         ser_out;

  int checks = 0;
  int fails  = 0;
  int model[W];   // model[0] is stage 1

  always #4 clk = ~clk;   // 125 MHz

  shreg_univ #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .shift_stb(shift_stb),
    .load_stb(load_stb), .ser_in(ser_in), .par_in(par_in),
    .q(q), .ser_out(ser_out)
  );

  function automatic logic [W-1:0] model_word();
    logic [W-1:0] w;
    for (int i = 0; i < W; i++) w[i] = model[i][0];
    return w;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, update model at the edge, compare at next negedge.
  task automatic cyc(input string tag, input logic r, input logic m,
                     input logic sh, input logic ld, input logic si,
                     input logic [W-1:0] pi);
    rst = r; mode = m; shift_stb = sh; load_stb = ld; ser_in = si; par_in = pi;
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < W; i++) model[i] = 0;
    end else if (m && ld) begin
      for (int i = 0; i < W; i++) model[i] = int'(pi[i]);
    end else if (!m && sh) begin
      for (int i = W - 1; i > 0; i--) model[i] = model[i-1];
      model[0] = int'(si);
    end
    @(negedge clk);
    check(tag, q, model_word());
    check("R8 ser_out", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, model_word()[W-1]});
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] got;
    logic         bits[$];
    for (int i = 0; i < W; i++) model[i] = 0;
    @(negedge clk);
    cyc("R1 reset", 1, 1, 1, 1, 1, 4'hF);
    cyc("R7 idle", 0, 0, 0, 0, 1, 4'hF);
    // R3 load, then mismatched strobes R4 R5
    cyc("R3 load", 0, 1, 0, 1, 0, 4'hA);
    cyc("R4 shift in load mode", 0, 1, 1, 0, 1, 4'h5);
    cyc("R5 load in shift mode", 0, 0, 0, 1, 1, 4'h5);
    cyc("R7 hold", 0, 1, 0, 0, 1, 4'h0);
    // R6 both strobes
    cyc("R6 both mode1", 0, 1, 1, 1, 1, 4'h6);
    cyc("R6 both mode0", 0, 0, 1, 1, 1, 4'h9);
    // R1 reset beats strobe
    cyc("R1 reset over load", 1, 1, 0, 1, 0, 4'hF);
    cyc("R3 load F", 0, 1, 0, 1, 0, 4'hF);
    cyc("R1 reset over shift", 1, 0, 1, 0, 1, 4'hF);
    // R9 serial to parallel, random
    for (int k = 0; k < 20; k++) begin
      bits.delete();
      for (int b = 0; b < 4; b++) begin
        logic s;
        s = 1'($urandom_range(0, 1));
        bits.push_back(s);
        cyc("R2 shift", 0, 0, 1, 0, s, 4'($urandom));
      end
      check("R9 parallel word", q, {bits[0], bits[1], bits[2], bits[3]});
    end
    // R10 round trip
    for (int k = 0; k < 16; k++) begin
      logic [W-1:0] word;
      word = 4'(k * 7 + 3);
      cyc("R3 load", 0, 1, 0, 1, 0, word);
      got[3] = ser_out;
      for (int b = 2; b >= 0; b--) begin
        cyc("R2 unload", 0, 0, 1, 0, 0, 4'h0);
        got[b] = ser_out;
      end
      check("R10 round trip", got, word);
    end
    // random mix
    for (int k = 0; k < 400; k++)
      cyc("R6 random", ($urandom_range(0, 19) == 0), 1'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom), 4'($urandom));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule